// File: doc/BRIEF.md
# Commit-Stage Squash Resolver

This block sits at the retire end of an out-of-order pipeline and decides, for every hardware thread on its own, whether a squash happens in a given cycle and where it lands. Three sources can ask for a squash. A trap request and a context request each flush the whole thread. An execute-stage request flushes only the instructions younger than a given sequence number. The block picks one winner per thread. It then computes the point at which the reorder buffer must cut, the last surviving sequence number and whether the branch delay slot dies. It also returns the redirect PC and the mispredict flag that the front end needs.

Each thread keeps a record of its youngest live sequence number. An execute-stage squash that would cut behind that point is dropped. This stops a late, younger squash from undoing an older one that already won. After a squash the thread stays in a squashing state until the reorder buffer reports that its walk is finished. While every thread is squashing, the instruction insert stream is back-pressured so new instructions wait in the upstream skid buffer. A running total counts accepted mispredict squashes.

The insert stream is valid/ready per thread. An insert is taken on a cycle where `ins_valid` and `ins_ready` are both high. `ins_ready` is low on every thread while all threads are squashing, and the producer must then hold its data. All other pins are plain per-cycle controls.

Top module: `commit_squash_resolver`

## Requirements
- R1: A trap request or a context request squashes the whole thread. The ROB squash point and the done point are the ROB head sequence number minus one, or 0 when that thread's ROB is empty. The redirect PC is the thread's saved PC, the mispredict output is 0, the delay-slot flag is 0 and the youngest sequence number becomes 0. Trap and context requests for the same thread must never be high together.
- R2: When a whole-thread request and an execute-stage squash reach the same thread in the same cycle, the whole-thread squash is the one carried out and the execute-stage request is dropped.
- R3: An execute-stage squash is accepted only if the thread's trap-pending input is low and its sequence number is at or below the youngest sequence number (unsigned compare). Otherwise it has no effect: no broadcast, no state change.
- R4: For an accepted execute-stage squash with mispredict, taken and conditional-delay-slot all high, the ROB squash point equals the sequence number and the delay-slot flag is 1. For any other mispredict, the squash point is the sequence number plus one and the flag is 0. Without mispredict, the squash point is the sequence number and the flag is 0. The done point is the sequence number.
- R5: With include-self high, both the squash point and the done point of an execute-stage squash are one lower than in R4 (unsigned wrap).
- R6: Results are registered. `sq_fire` pulses for exactly the cycle after the accepting edge, with the squash point, done point, delay-slot flag, mispredict flag and redirect PC valid alongside it. The youngest sequence number then equals the done point.
- R7: After any accepted squash, `rob_squashing` is high and stays high until an edge where `rob_done` is high and no new squash is accepted.
- R8: `ins_ready` is low on all threads while every thread is squashing, and high otherwise. An accepted insert sets that thread's youngest sequence number to the inserted value. A squash in the same cycle overrides it.
- R9: `mispred_count` increases by one for every accepted execute-stage squash with the mispredict flag high, summed across threads.
- R10: After reset no thread is squashing, `sq_fire` is 0, `ins_ready` is high, the mispredict count is 0 and every youngest sequence number is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | NT | Per-thread trap squash request |
| ctx_req | input | NT | Per-thread context squash request |
| trap_pending | input | NT | Thread has a trap in flight; blocks execute squashes |
| rob_empty | input | NT | Thread's ROB holds no entries |
| rob_head_seq | input | NT×SEQ_W | Sequence number at each thread's ROB head |
| saved_pc | input | NT×PC_W | Restart PC for whole-thread squashes |
| ex_valid | input | NT | Execute-stage squash request |
| ex_seq | input | NT×SEQ_W | Sequence number of the squashing instruction |
| ex_incl | input | NT | Squash includes the instruction itself |
| ex_mispred | input | NT | Request comes from a branch mispredict |
| ex_taken | input | NT | Branch resolved taken |
| ex_cond_ds | input | NT | Branch is a conditional delay-slot branch |
| ex_pc | input | NT×PC_W | Redirect PC from execute |
| rob_done | input | NT | ROB has finished its squash walk |
| ins_valid | input | NT | Insert stream valid |
| ins_seq | input | NT×SEQ_W | Sequence number of inserted instruction |
| ins_ready | output | NT | Insert stream ready |
| sq_fire | output | NT | Squash broadcast pulse |
| sq_rob_pt | output | NT×SEQ_W | ROB squash point |
| sq_done_pt | output | NT×SEQ_W | Last surviving sequence number |
| sq_ds | output | NT | Delay slot is squashed |
| sq_mispred | output | NT | Squash was a branch mispredict |
| sq_pc | output | NT×PC_W | Redirect PC |
| rob_squashing | output | NT | Thread is in the squashing state |
| youngest_seq | output | NT×SEQ_W | Youngest live sequence number per thread |
| mispred_count | output | CNT_W | Accepted mispredict squash total |

## Verification
The collision that matters is a whole-thread request and an execute-stage mispredict hitting the same thread at the same edge. The bench drives both together with different redirect PCs. It judges the winner by the redirect PC, the cleared mispredict flag, the head-minus-one squash point and an unchanged mispredict total. A second collision is an insert that is offered while every thread is squashing. It is judged by reading that thread's youngest sequence number afterwards, which must not move.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic {
    TS_RUN = 1'b0,
    TS_SQ  = 1'b1
  } thr_state_e;

  typedef enum logic [1:0] {
    SQK_NONE  = 2'd0,
    SQK_WHOLE = 2'd1,
    SQK_EXEC  = 2'd2
  } sq_kind_e;
endpackage

// File: rtl/squash_point_calc.sv
module squash_point_calc
  import cs_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32
) (
  input  logic             trap_req,
  input  logic             ctx_req,
  input  logic             trap_pending,
  input  logic             rob_empty,
  input  logic [SEQ_W-1:0] rob_head_seq,
  input  logic [PC_W-1:0]  saved_pc,
  input  logic             ex_valid,
  input  logic [SEQ_W-1:0] ex_seq,
  input  logic             ex_incl,
  input  logic             ex_mispred,
  input  logic             ex_taken,
  input  logic             ex_cond_ds,
  input  logic [PC_W-1:0]  ex_pc,
  input  logic [SEQ_W-1:0] youngest,
  output sq_kind_e         kind,
  output logic [SEQ_W-1:0] rob_pt,
  output logic [SEQ_W-1:0] done_pt,
  output logic             ds_kill,
  output logic             mis_out,
  output logic [PC_W-1:0]  pc_out
);
  localparam logic [SEQ_W-1:0] ONE = SEQ_W'(1);

  logic             whole_req;
  logic             ex_ok;
  logic [SEQ_W-1:0] whole_pt;
  logic [SEQ_W-1:0] ex_base;
  logic [SEQ_W-1:0] ex_cut;
  logic             ex_ds;

  assign whole_req = trap_req | ctx_req;
  assign ex_ok     = ex_valid && !trap_pending && (ex_seq <= youngest);
  assign whole_pt  = rob_empty ? '0 : rob_head_seq - ONE;

  always_comb begin
    ex_ds  = 1'b0;
    ex_cut = ex_seq;
    if (ex_mispred) begin
      if (ex_taken && ex_cond_ds) begin
        ex_ds  = 1'b1;
        ex_cut = ex_seq;
      end else begin
        ex_cut = ex_seq + ONE;
      end
    end
    ex_base = ex_seq;
    if (ex_incl) begin
      ex_base = ex_seq - ONE;
      ex_cut  = ex_cut - ONE;
    end
  end

  always_comb begin
    kind    = SQK_NONE;
    rob_pt  = '0;
    done_pt = '0;
    ds_kill = 1'b0;
    mis_out = 1'b0;
    pc_out  = '0;
    if (whole_req) begin
      kind    = SQK_WHOLE;
      rob_pt  = whole_pt;
      done_pt = whole_pt;
      pc_out  = saved_pc;
    end else if (ex_ok) begin
      kind    = SQK_EXEC;
      rob_pt  = ex_cut;
      done_pt = ex_base;
      ds_kill = ex_ds;
      mis_out = ex_mispred;
      pc_out  = ex_pc;
    end
  end
endmodule

// File: rtl/thread_squash_ctl.sv
module thread_squash_ctl
  import cs_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_req,
  input  logic             ctx_req,
  input  logic             trap_pending,
  input  logic             rob_empty,
  input  logic [SEQ_W-1:0] rob_head_seq,
  input  logic [PC_W-1:0]  saved_pc,
  input  logic             ex_valid,
  input  logic [SEQ_W-1:0] ex_seq,
  input  logic             ex_incl,
  input  logic             ex_mispred,
  input  logic             ex_taken,
  input  logic             ex_cond_ds,
  input  logic [PC_W-1:0]  ex_pc,
  input  logic             rob_done,
  input  logic             ins_take,
  input  logic [SEQ_W-1:0] ins_seq,
  output logic             fire_o,
  output logic [SEQ_W-1:0] rob_pt_o,
  output logic [SEQ_W-1:0] done_pt_o,
  output logic             ds_o,
  output logic             mis_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             squashing_o,
  output logic [SEQ_W-1:0] youngest_o,
  output logic             mis_accept
);
  thr_state_e       state_q;
  logic [SEQ_W-1:0] youngest_q;
  sq_kind_e         kind;
  logic [SEQ_W-1:0] rob_pt_c;
  logic [SEQ_W-1:0] done_pt_c;
  logic             ds_c;
  logic             mis_c;
  logic [PC_W-1:0]  pc_c;

  squash_point_calc #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_calc (
    .trap_req     (trap_req),
    .ctx_req      (ctx_req),
    .trap_pending (trap_pending),
    .rob_empty    (rob_empty),
    .rob_head_seq (rob_head_seq),
    .saved_pc     (saved_pc),
    .ex_valid     (ex_valid),
    .ex_seq       (ex_seq),
    .ex_incl      (ex_incl),
    .ex_mispred   (ex_mispred),
    .ex_taken     (ex_taken),
    .ex_cond_ds   (ex_cond_ds),
    .ex_pc        (ex_pc),
    .youngest     (youngest_q),
    .kind         (kind),
    .rob_pt       (rob_pt_c),
    .done_pt      (done_pt_c),
    .ds_kill      (ds_c),
    .mis_out      (mis_c),
    .pc_out       (pc_c)
  );

  assign mis_accept = (kind == SQK_EXEC) && mis_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= TS_RUN;
      youngest_q <= '1;
      fire_o     <= 1'b0;
      rob_pt_o   <= '0;
      done_pt_o  <= '0;
      ds_o       <= 1'b0;
      mis_o      <= 1'b0;
      pc_o       <= '0;
    end else begin
      fire_o <= (kind != SQK_NONE);
      if (kind != SQK_NONE) begin
        state_q    <= TS_SQ;
        youngest_q <= (kind == SQK_WHOLE) ? '0 : done_pt_c;
        rob_pt_o   <= rob_pt_c;
        done_pt_o  <= done_pt_c;
        ds_o       <= ds_c;
        mis_o      <= mis_c;
        pc_o       <= pc_c;
      end else begin
        if (ins_take) youngest_q <= ins_seq;
        if (state_q == TS_SQ && rob_done) state_q <= TS_RUN;
      end
    end
  end

  assign squashing_o = (state_q == TS_SQ);
  assign youngest_o  = youngest_q;

  // R1
  no_dual_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_req && ctx_req));

  // R1
  whole_resets_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req || ctx_req) |=> (youngest_o == '0) && !mis_o && fire_o);

  // R3
  young_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && (ex_seq > youngest_q) && !trap_req && !ctx_req) |=> !fire_o);

  // R7
  sq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (squashing_o && !rob_done) |=> squashing_o);

  // R6
  fire_marks_sq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> squashing_o && (youngest_o == done_pt_o || youngest_o == '0));
endmodule

// File: rtl/mispred_tally.sv
module mispred_tally #(
  parameter int NT    = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NT-1:0]    hit,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] add_c;

  always_comb begin
    add_c = '0;
    for (int i = 0; i < NT; i++) add_c = add_c + CNT_W'(hit[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count + add_c;
  end

  // R9
  tally_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |=> $stable(count));
endmodule

// File: rtl/commit_squash_resolver.sv
module commit_squash_resolver
  import cs_pkg::*;
#(
  parameter int NT    = 2,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NT-1:0]             trap_req,
  input  logic [NT-1:0]             ctx_req,
  input  logic [NT-1:0]             trap_pending,
  input  logic [NT-1:0]             rob_empty,
  input  logic [NT-1:0][SEQ_W-1:0]  rob_head_seq,
  input  logic [NT-1:0][PC_W-1:0]   saved_pc,
  input  logic [NT-1:0]             ex_valid,
  input  logic [NT-1:0][SEQ_W-1:0]  ex_seq,
  input  logic [NT-1:0]             ex_incl,
  input  logic [NT-1:0]             ex_mispred,
  input  logic [NT-1:0]             ex_taken,
  input  logic [NT-1:0]             ex_cond_ds,
  input  logic [NT-1:0][PC_W-1:0]   ex_pc,
  input  logic [NT-1:0]             rob_done,
  input  logic [NT-1:0]             ins_valid,
  input  logic [NT-1:0][SEQ_W-1:0]  ins_seq,
  output logic [NT-1:0]             ins_ready,
  output logic [NT-1:0]             sq_fire,
  output logic [NT-1:0][SEQ_W-1:0]  sq_rob_pt,
  output logic [NT-1:0][SEQ_W-1:0]  sq_done_pt,
  output logic [NT-1:0]             sq_ds,
  output logic [NT-1:0]             sq_mispred,
  output logic [NT-1:0][PC_W-1:0]   sq_pc,
  output logic [NT-1:0]             rob_squashing,
  output logic [NT-1:0][SEQ_W-1:0]  youngest_seq,
  output logic [CNT_W-1:0]          mispred_count
);
  logic          all_sq;
  logic [NT-1:0] mis_hit;
  logic [NT-1:0] ins_take;

  assign all_sq    = &rob_squashing;
  assign ins_ready = {NT{!all_sq}};
  assign ins_take  = ins_valid & ins_ready;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    thread_squash_ctl #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_thr (
      .clk          (clk),
      .rst_n        (rst_n),
      .trap_req     (trap_req[t]),
      .ctx_req      (ctx_req[t]),
      .trap_pending (trap_pending[t]),
      .rob_empty    (rob_empty[t]),
      .rob_head_seq (rob_head_seq[t]),
      .saved_pc     (saved_pc[t]),
      .ex_valid     (ex_valid[t]),
      .ex_seq       (ex_seq[t]),
      .ex_incl      (ex_incl[t]),
      .ex_mispred   (ex_mispred[t]),
      .ex_taken     (ex_taken[t]),
      .ex_cond_ds   (ex_cond_ds[t]),
      .ex_pc        (ex_pc[t]),
      .rob_done     (rob_done[t]),
      .ins_take     (ins_take[t]),
      .ins_seq      (ins_seq[t]),
      .fire_o       (sq_fire[t]),
      .rob_pt_o     (sq_rob_pt[t]),
      .done_pt_o    (sq_done_pt[t]),
      .ds_o         (sq_ds[t]),
      .mis_o        (sq_mispred[t]),
      .pc_o         (sq_pc[t]),
      .squashing_o  (rob_squashing[t]),
      .youngest_o   (youngest_seq[t]),
      .mis_accept   (mis_hit[t])
    );
  end

  mispred_tally #(.NT(NT), .CNT_W(CNT_W)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (mis_hit),
    .count (mispred_count)
  );

  // R8
  hold_inserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&rob_squashing) |-> (ins_ready == '0));

  // R8
  open_inserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&rob_squashing) |-> (ins_ready == '1));
endmodule

// File: tb/test_commit_squash_resolver.sv
module test_commit_squash_resolver;
  localparam int NT = 2, SEQ_W = 16, PC_W = 32, CNT_W = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 9;
  // {seq, incl, mis, taken, cds, accept, exp_rob_pt, exp_done, exp_ds}
  localparam logic [53:0] VEC [NV] = '{
    {16'd50,  1'b0,1'b0,1'b0,1'b0, 1'b1, 16'd50,    16'd50,    1'b0},
    {16'd50,  1'b0,1'b1,1'b1,1'b1, 1'b1, 16'd50,    16'd50,    1'b1},
    {16'd50,  1'b0,1'b1,1'b0,1'b1, 1'b1, 16'd51,    16'd50,    1'b0},
    {16'd50,  1'b0,1'b1,1'b1,1'b0, 1'b1, 16'd51,    16'd50,    1'b0},
    {16'd50,  1'b1,1'b1,1'b1,1'b1, 1'b1, 16'd49,    16'd49,    1'b1},
    {16'd50,  1'b1,1'b1,1'b0,1'b0, 1'b1, 16'd50,    16'd49,    1'b0},
    {16'd100, 1'b0,1'b0,1'b0,1'b0, 1'b1, 16'd100,   16'd100,   1'b0},
    {16'd101, 1'b0,1'b1,1'b0,1'b0, 1'b0, 16'd0,     16'd0,     1'b0},
    {16'd0,   1'b1,1'b0,1'b0,1'b0, 1'b1, 16'hFFFF,  16'hFFFF,  1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NT-1:0] trap_req = '0, ctx_req = '0, trap_pending = '0, rob_empty = '0;
  logic [NT-1:0][SEQ_W-1:0] rob_head_seq = '0, ex_seq = '0, ins_seq = '0;
  logic [NT-1:0][PC_W-1:0] saved_pc = '0, ex_pc = '0;
  logic [NT-1:0] ex_valid = '0, ex_incl = '0, ex_mispred = '0, ex_taken = '0, ex_cond_ds = '0;
  logic [NT-1:0] rob_done = '0, ins_valid = '0;
  logic [NT-1:0] ins_ready, sq_fire, sq_ds, sq_mispred, rob_squashing;
  logic [NT-1:0][SEQ_W-1:0] sq_rob_pt, sq_done_pt, youngest_seq;
  logic [NT-1:0][PC_W-1:0] sq_pc;
  logic [CNT_W-1:0] mispred_count;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  commit_squash_resolver #(.NT(NT), .SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)) i_commit_squash_resolver (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .ctx_req(ctx_req),
    .trap_pending(trap_pending), .rob_empty(rob_empty), .rob_head_seq(rob_head_seq),
    .saved_pc(saved_pc), .ex_valid(ex_valid), .ex_seq(ex_seq), .ex_incl(ex_incl),
    .ex_mispred(ex_mispred), .ex_taken(ex_taken), .ex_cond_ds(ex_cond_ds), .ex_pc(ex_pc),
    .rob_done(rob_done), .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_ready(ins_ready),
    .sq_fire(sq_fire), .sq_rob_pt(sq_rob_pt), .sq_done_pt(sq_done_pt), .sq_ds(sq_ds),
    .sq_mispred(sq_mispred), .sq_pc(sq_pc), .rob_squashing(rob_squashing),
    .youngest_seq(youngest_seq), .mispred_count(mispred_count)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input int t, input logic [SEQ_W-1:0] s);
    ins_valid[t] = 1'b1; ins_seq[t] = s;
    tick();
    ins_valid[t] = 1'b0;
  endtask

  task automatic finish_sq(input logic [NT-1:0] m);
    rob_done = m;
    tick();
    rob_done = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk(rob_squashing == '0, "R10 squashing", rob_squashing, 0);
    chk(sq_fire == '0, "R10 fire", sq_fire, 0);
    chk(ins_ready == '1, "R10 ready", ins_ready, 3);
    chk(mispred_count == 0, "R10 count", mispred_count, 0);
    chk(youngest_seq[0] == 16'hFFFF, "R10 youngest", youngest_seq[0], 16'hFFFF);

    // R4 R5 R3 R6 vector walk on thread 0
    for (int v = 0; v < NV; v++) begin
      logic [53:0] w;
      w = VEC[v];
      put(0, 16'd100);
      ex_valid[0] = 1'b1; ex_seq[0] = w[53:38]; ex_incl[0] = w[37];
      ex_mispred[0] = w[36]; ex_taken[0] = w[35]; ex_cond_ds[0] = w[34];
      ex_pc[0] = 32'h4000 + v;
      tick();
      ex_valid[0] = 1'b0;
      chk(sq_fire[0] == w[33], "R3 accept", sq_fire[0], w[33]);
      if (w[33]) begin
        chk(sq_rob_pt[0] == w[32:17], "R4/R5 rob point", sq_rob_pt[0], w[32:17]);
        chk(sq_done_pt[0] == w[16:1], "R5 done point", sq_done_pt[0], w[16:1]);
        chk(sq_ds[0] == w[0], "R4 delay slot", sq_ds[0], w[0]);
        chk(sq_pc[0] == 32'h4000 + v, "R6 redirect", sq_pc[0], 32'h4000 + v);
        chk(youngest_seq[0] == w[16:1], "R6 youngest", youngest_seq[0], w[16:1]);
        chk(rob_squashing[0] == 1'b1, "R7 squashing", rob_squashing[0], 1);
        tick();
        chk(sq_fire[0] == 1'b0, "R6 pulse", sq_fire[0], 0);
      end else begin
        chk(youngest_seq[0] == 16'd100, "R3 ignored", youngest_seq[0], 100);
      end
      finish_sq(2'b01);
    end
    // R9 five accepted mispredicts
    chk(mispred_count == 5, "R9 count", mispred_count, 5);

    // R1 R2 trap and execute mispredict collide
    put(0, 16'd100);
    trap_req[0] = 1'b1; rob_head_seq[0] = 16'd20; saved_pc[0] = 32'h1000;
    ex_valid[0] = 1'b1; ex_seq[0] = 16'd5; ex_mispred[0] = 1'b1; ex_pc[0] = 32'h2000;
    tick();
    trap_req[0] = 1'b0; ex_valid[0] = 1'b0; ex_mispred[0] = 1'b0;
    chk(sq_pc[0] == 32'h1000, "R2 winner pc", sq_pc[0], 32'h1000);
    chk(sq_rob_pt[0] == 16'd19, "R1 head-1", sq_rob_pt[0], 19);
    chk(sq_mispred[0] == 1'b0, "R1 mispred clear", sq_mispred[0], 0);
    chk(youngest_seq[0] == 0, "R1 youngest 0", youngest_seq[0], 0);
    chk(mispred_count == 5, "R2 count unchanged", mispred_count, 5);

    // R7 stays squashing until done; R3 younger than 0 rejected
    tick(); tick(); tick();
    chk(rob_squashing[0] == 1'b1, "R7 hold", rob_squashing[0], 1);
    ex_valid[0] = 1'b1; ex_seq[0] = 16'd5;
    tick();
    ex_valid[0] = 1'b0;
    chk(sq_fire[0] == 1'b0, "R3 younger rejected", sq_fire[0], 0);
    finish_sq(2'b01);
    chk(rob_squashing[0] == 1'b0, "R7 release", rob_squashing[0], 0);

    // R1 context squash with empty ROB
    ctx_req[0] = 1'b1; rob_empty[0] = 1'b1; saved_pc[0] = 32'h3300;
    tick();
    ctx_req[0] = 1'b0; rob_empty[0] = 1'b0;
    chk(sq_fire[0] && sq_rob_pt[0] == 0, "R1 empty point", sq_rob_pt[0], 0);
    chk(sq_pc[0] == 32'h3300, "R1 ctx pc", sq_pc[0], 32'h3300);
    finish_sq(2'b01);

    // R3 trap pending blocks execute squash
    put(0, 16'd100);
    trap_pending[0] = 1'b1; ex_valid[0] = 1'b1; ex_seq[0] = 16'd50;
    tick();
    trap_pending[0] = 1'b0; ex_valid[0] = 1'b0;
    chk(sq_fire[0] == 1'b0, "R3 trap pending", sq_fire[0], 0);
    chk(rob_squashing[0] == 1'b0, "R3 no state", rob_squashing[0], 0);

    // R8 all threads squashing holds inserts
    ctx_req = 2'b11;
    tick();
    ctx_req = '0;
    chk(ins_ready == '0, "R8 ready low", ins_ready, 0);
    put(1, 16'd77);
    chk(youngest_seq[1] == 0, "R8 insert held", youngest_seq[1], 0);
    finish_sq(2'b11);
    chk(ins_ready == '1, "R8 ready high", ins_ready, 3);
    put(1, 16'd300);
    chk(youngest_seq[1] == 16'd300, "R8 insert taken", youngest_seq[1], 300);

    // R6 per-thread independence
    ex_valid[1] = 1'b1; ex_seq[1] = 16'd200;
    tick();
    ex_valid[1] = 1'b0;
    chk(sq_fire == 2'b10, "R6 thread isolation", sq_fire, 2);
    chk(rob_squashing[0] == 1'b0, "R6 thread0 idle", rob_squashing[0], 0);
    finish_sq(2'b10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule